// File: doc/BRIEF.md
# Multi-Format Page Table Walker

This block translates a virtual address into a physical address. It reads page-table entries from memory one level at a time. A translation request carries the virtual address, the physical base of the top-level table and a format select. The walker then issues entry reads on a simple valid/ready memory port, with only one read outstanding. It stops at a leaf entry or at a fault. Its result is a one-cycle done pulse carrying either the physical address or a fault code, together with the table level at which the walk ended.

One state machine serves three table formats. The first is a four-level format with 8-byte entries, 9 index bits per level and a 48-bit virtual address. The second is a three-level format for 32-bit virtual addresses with 8-byte entries: a 4-entry top table, then two 512-entry tables. The third is a two-level format with 4-byte entries and 10 index bits per level. Pages are 4 KiB. Large leaves of 2 MiB and 1 GiB are recognised where the format allows them.

Top module: `ptw_top`

## Requirements
- R1: After reset the walker is idle: req_ready is 1, done_valid is 0 and mem_req_valid is 0.
- R2: In format 0 (four-level), the walker makes four 8-byte reads (mem_req_size8=1). Entry address = table base + index*8, and the index for level L (3 = top, 0 = last) is va[12+9L+8:12+9L]. Each entry's bits 51:12 form the next base. The result is {leaf bits 51:12, va[11:0]} with done_level 0. Entry bits 63:52 have no effect.
- R3: In format 0, entry bit 7 set at level 1 ends the walk with a 2 MiB page: pa = leaf base with bits 20:0 taken from va, after 3 reads. The same bit at level 2 ends it with a 1 GiB page: bits 29:0 taken from va, after 2 reads. done_level reports the leaf level.
- R4: Entry bit 7 has no effect at level 3 of format 0 or at level 0 of any format. The walk continues, or ends with a 4 KiB page, as if the bit were clear.
- R5: In format 1 (three-level), the top index is va[31:30] and the next indices are va[29:21] and va[20:12]. There are 3 reads of 8 bytes, and va bits above 31 have no effect. Bit 7 at level 1 gives a 2 MiB page.
- R6: In format 2 (two-level), there are 2 reads of 4 bytes (mem_req_size8=0). Entry address = base + index*4, with index va[31:22], then va[21:12]. Only bits 31:0 of the response are used, and bits 31:12 form the base. Bit 7 has no effect.
- R7: An entry with bit 0 clear ends the walk with done_fault_kind 1, done_level set to that entry's level and done_pa 0.
- R8: An 8-byte entry that has bit 0 set and any bit from IMPL_PA_W (default 46) to 51 set ends the walk with done_fault_kind 2 at that level. Bits below IMPL_PA_W are valid address bits. The present check takes priority.
- R9: Format select 3 gives done_fault_kind 3, done_level 0, with no memory read. done_valid rises on the cycle after acceptance.
- R10: req_ready is 1 only while idle, so a request presented during a walk is ignored. done_valid lasts exactly one cycle.
- R11: While mem_req_valid is 1 and mem_req_ready is 0, mem_req_addr and mem_req_size8 hold steady. No new read is issued while one is pending.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Translation request present |
| req_ready | output | 1 | Walker idle, request accepted this cycle |
| req_va | input | VA_W | Virtual address |
| req_root | input | PA_W | Physical base of the top-level table |
| req_mode | input | 2 | Format: 0 four-level, 1 three-level, 2 two-level, 3 invalid |
| mem_req_valid | output | 1 | Entry read request |
| mem_req_ready | input | 1 | Memory accepts the read |
| mem_req_addr | output | PA_W | Entry byte address |
| mem_req_size8 | output | 1 | 1 = 8-byte read, 0 = 4-byte read |
| mem_rsp_valid | input | 1 | Read data valid |
| mem_rsp_data | input | 64 | Read data (4-byte reads use bits 31:0) |
| done_valid | output | 1 | One-cycle result pulse |
| done_pa | output | PA_W | Physical address (0 on fault) |
| done_fault_kind | output | 2 | 0 none, 1 not present, 2 reserved bit, 3 invalid format |
| done_level | output | 2 | Level at which the walk ended |

## Verification
Two situations are hard to reach from the ports. The first is a reserved-bit fault at an intermediate level, which occurs only when the entries above it are valid. The bench builds tables in which the upper levels are correct and only the chosen level carries the offending bit. It also places a valid high address bit just below the implemented width on a leaf. The second is a read held by back-pressure: the memory model grants only one cycle in four, so each request waits several cycles, and a monitor checks that address and size stay fixed throughout.

// File: rtl/ptw_pkg.sv
package ptw_pkg;

   typedef enum logic [1:0] {
      FMT_L4  = 2'd0,
      FMT_L3X = 2'd1,
      FMT_L2  = 2'd2,
      FMT_BAD = 2'd3
   } walk_fmt_e;

   typedef enum logic [1:0] {
      FLT_NONE   = 2'd0,
      FLT_ABSENT = 2'd1,
      FLT_RSVD   = 2'd2,
      FLT_FMT    = 2'd3
   } walk_flt_e;

   typedef enum logic [1:0] {
      ST_IDLE  = 2'd0,
      ST_ISSUE = 2'd1,
      ST_WAIT  = 2'd2,
      ST_DONE  = 2'd3
   } walk_st_e;

   localparam int unsigned PG_SHIFT = 12;
   localparam int unsigned ENTRY_W  = 64;

   function automatic logic [1:0] top_level(input walk_fmt_e fmt);
      case (fmt)
         FMT_L4:  return 2'd3;
         FMT_L3X: return 2'd2;
         default: return 2'd1;
      endcase
   endfunction

   function automatic logic big_leaf_ok(input walk_fmt_e fmt, input logic [1:0] lvl);
      case (fmt)
         FMT_L4:  return (lvl == 2'd1) || (lvl == 2'd2);
         FMT_L3X: return (lvl == 2'd1);
         default: return 1'b0;
      endcase
   endfunction

   function automatic logic fmt_wide(input walk_fmt_e fmt);
      return fmt != FMT_L2;
   endfunction

endpackage

// File: rtl/ptw_index_gen.sv
module ptw_index_gen
   import ptw_pkg::*;
#(
   parameter int unsigned VA_W = 48,
   parameter int unsigned PA_W = 52
) (
   input  logic [VA_W-1:0] va,
   input  logic [PA_W-1:0] tbl_base,
   input  walk_fmt_e       fmt,
   input  logic [1:0]      lvl,
   output logic [PA_W-1:0] entry_addr,
   output logic            wide
);
   localparam int unsigned IDX_W_WIDE   = 9;
   localparam int unsigned IDX_W_NARROW = 10;
   localparam int unsigned OFF_W        = IDX_W_NARROW + 3;

   logic [IDX_W_WIDE-1:0]   idx_wide;
   logic [IDX_W_NARROW-1:0] idx_narrow;
   logic [OFF_W-1:0]        byte_off;

   always_comb begin
      case (lvl)
         2'd0:    idx_wide = va[20:12];
         2'd1:    idx_wide = va[29:21];
         2'd2:    idx_wide = va[38:30];
         default: idx_wide = va[47:39];
      endcase
      if (fmt == FMT_L3X && lvl == 2'd2) begin
         idx_wide = {{(IDX_W_WIDE-2){1'b0}}, va[31:30]};
      end
      idx_narrow = (lvl == 2'd0) ? va[21:12] : va[31:22];
   end

   assign wide     = fmt_wide(fmt);
   assign byte_off = wide ? {1'b0, idx_wide, 3'b000} : {1'b0, idx_narrow, 2'b00};
   assign entry_addr = tbl_base + PA_W'(byte_off);

   logic unused_va_low;
   assign unused_va_low = ^va[PG_SHIFT-1:0];

   if (VA_W > 48) begin : g_va_wide
      logic unused_va_high;
      assign unused_va_high = ^va[VA_W-1:48];
   end

endmodule

// File: rtl/ptw_entry_dec.sv
module ptw_entry_dec
   import ptw_pkg::*;
#(
   parameter int unsigned PA_W      = 52,
   parameter int unsigned IMPL_PA_W = 46
) (
   input  logic [ENTRY_W-1:0] entry,
   input  logic               wide,
   output logic               present,
   output logic               big_flag,
   output logic               rsvd_bad,
   output logic [PA_W-1:0]    next_base
);
   localparam int unsigned FIELD_TOP = 51;

   assign present  = entry[0];
   assign big_flag = entry[7];

   logic [PA_W-1:0] base_wide;
   logic [PA_W-1:0] base_narrow;

   assign base_wide   = {entry[PA_W-1:PG_SHIFT], {PG_SHIFT{1'b0}}};
   assign base_narrow = PA_W'({entry[31:PG_SHIFT], {PG_SHIFT{1'b0}}});
   assign next_base   = wide ? base_wide : base_narrow;

   if (IMPL_PA_W <= FIELD_TOP) begin : g_rsvd_chk
      assign rsvd_bad = wide & (|entry[FIELD_TOP:IMPL_PA_W]);
   end else begin : g_rsvd_none
      assign rsvd_bad = 1'b0;
   end

   if (PA_W < FIELD_TOP + 1) begin : g_pa_narrow_field
      logic unused_field_top;
      assign unused_field_top = ^entry[FIELD_TOP:PA_W];
   end

   logic unused_entry_bits;
   assign unused_entry_bits = ^{entry[ENTRY_W-1:FIELD_TOP+1], entry[11:8], entry[6:1]};

endmodule

// File: rtl/ptw_leaf_pa.sv
module ptw_leaf_pa
   import ptw_pkg::*;
#(
   parameter int unsigned VA_W = 48,
   parameter int unsigned PA_W = 52
) (
   input  logic [PA_W-1:0] leaf_base,
   input  logic [VA_W-1:0] va,
   input  logic [1:0]      lvl,
   output logic [PA_W-1:0] pa
);
   logic [PA_W-1:0] va_ext;
   logic [PA_W-1:0] keep_mask;
   int unsigned     off_bits;

   if (VA_W >= PA_W) begin : g_va_trunc
      assign va_ext = va[PA_W-1:0];
   end else begin : g_va_zext
      assign va_ext = {{(PA_W-VA_W){1'b0}}, va};
   end

   always_comb begin
      case (lvl)
         2'd0:    off_bits = PG_SHIFT;
         2'd1:    off_bits = PG_SHIFT + 9;
         default: off_bits = PG_SHIFT + 18;
      endcase
      keep_mask = (PA_W'(1) << off_bits) - PA_W'(1);
   end

   assign pa = (leaf_base & ~keep_mask) | (va_ext & keep_mask);

endmodule

// File: rtl/ptw_top.sv
module ptw_top
   import ptw_pkg::*;
#(
   parameter int unsigned VA_W      = 48,
   parameter int unsigned PA_W      = 52,
   parameter int unsigned IMPL_PA_W = 46
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            req_valid,
   output logic            req_ready,
   input  logic [VA_W-1:0] req_va,
   input  logic [PA_W-1:0] req_root,
   input  logic [1:0]      req_mode,
   output logic            mem_req_valid,
   input  logic            mem_req_ready,
   output logic [PA_W-1:0] mem_req_addr,
   output logic            mem_req_size8,
   input  logic            mem_rsp_valid,
   input  logic [63:0]     mem_rsp_data,
   output logic            done_valid,
   output logic [PA_W-1:0] done_pa,
   output logic [1:0]      done_fault_kind,
   output logic [1:0]      done_level
);
   if (VA_W < 48) begin : g_bad_va
      $error("ptw_top: VA_W must be at least 48");
   end
   if (PA_W < 32 || PA_W > 52) begin : g_bad_pa
      $error("ptw_top: PA_W must lie in 32..52");
   end
   if (IMPL_PA_W < 32 || IMPL_PA_W > PA_W) begin : g_bad_impl
      $error("ptw_top: IMPL_PA_W must lie in 32..PA_W");
   end

   walk_st_e        st_q;
   walk_fmt_e       fmt_q;
   logic [VA_W-1:0] va_q;
   logic [PA_W-1:0] base_q;
   logic [1:0]      lvl_q;
   logic [PA_W-1:0] pa_q;
   walk_flt_e       flt_q;
   logic [1:0]      end_lvl_q;

   logic            wide;
   logic            present;
   logic            big_flag;
   logic            rsvd_bad;
   logic [PA_W-1:0] next_base;
   logic [PA_W-1:0] leaf_pa;
   logic            accept;
   logic            is_leaf;

   ptw_index_gen #(.VA_W(VA_W), .PA_W(PA_W)) idx_i (
      .va         (va_q),
      .tbl_base   (base_q),
      .fmt        (fmt_q),
      .lvl        (lvl_q),
      .entry_addr (mem_req_addr),
      .wide       (wide)
   );

   ptw_entry_dec #(.PA_W(PA_W), .IMPL_PA_W(IMPL_PA_W)) dec_i (
      .entry     (mem_rsp_data),
      .wide      (wide),
      .present   (present),
      .big_flag  (big_flag),
      .rsvd_bad  (rsvd_bad),
      .next_base (next_base)
   );

   ptw_leaf_pa #(.VA_W(VA_W), .PA_W(PA_W)) leaf_i (
      .leaf_base (next_base),
      .va        (va_q),
      .lvl       (lvl_q),
      .pa        (leaf_pa)
   );

   assign req_ready     = (st_q == ST_IDLE);
   assign accept        = req_valid && req_ready;
   assign mem_req_valid = (st_q == ST_ISSUE);
   assign mem_req_size8 = wide;
   assign is_leaf       = (lvl_q == 2'd0) || (big_flag && big_leaf_ok(fmt_q, lvl_q));

   assign done_valid      = (st_q == ST_DONE);
   assign done_pa         = pa_q;
   assign done_fault_kind = flt_q;
   assign done_level      = end_lvl_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q      <= ST_IDLE;
         fmt_q     <= FMT_L4;
         va_q      <= '0;
         base_q    <= '0;
         lvl_q     <= 2'd0;
         pa_q      <= '0;
         flt_q     <= FLT_NONE;
         end_lvl_q <= 2'd0;
      end else begin
         case (st_q)
            ST_IDLE: begin
               if (accept) begin
                  fmt_q  <= walk_fmt_e'(req_mode);
                  va_q   <= req_va;
                  base_q <= req_root;
                  lvl_q  <= top_level(walk_fmt_e'(req_mode));
                  if (walk_fmt_e'(req_mode) == FMT_BAD) begin
                     pa_q      <= '0;
                     flt_q     <= FLT_FMT;
                     end_lvl_q <= 2'd0;
                     st_q      <= ST_DONE;
                  end else begin
                     st_q <= ST_ISSUE;
                  end
               end
            end
            ST_ISSUE: begin
               if (mem_req_ready) begin
                  st_q <= ST_WAIT;
               end
            end
            ST_WAIT: begin
               if (mem_rsp_valid) begin
                  end_lvl_q <= lvl_q;
                  if (!present) begin
                     pa_q  <= '0;
                     flt_q <= FLT_ABSENT;
                     st_q  <= ST_DONE;
                  end else if (rsvd_bad) begin
                     pa_q  <= '0;
                     flt_q <= FLT_RSVD;
                     st_q  <= ST_DONE;
                  end else if (is_leaf) begin
                     pa_q  <= leaf_pa;
                     flt_q <= FLT_NONE;
                     st_q  <= ST_DONE;
                  end else begin
                     base_q <= next_base;
                     lvl_q  <= lvl_q - 2'd1;
                     st_q   <= ST_ISSUE;
                  end
               end
            end
            default: begin
               st_q <= ST_IDLE;
            end
         endcase
      end
   end

   assert_rst_idle_R1: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(rst_n) |-> req_ready && !done_valid && !mem_req_valid);

   assert_start_read_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && req_ready && req_mode != 2'd3) |=> mem_req_valid);

   assert_fault_pa_zero_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (done_valid && done_fault_kind != 2'd0) |-> (done_pa == '0));

   assert_bad_fmt_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && req_ready && req_mode == 2'd3)
      |=> (done_valid && done_fault_kind == 2'd3 && !mem_req_valid));

   assert_busy_blocks_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_req_valid || mem_rsp_valid) |-> !req_ready);

   assert_done_pulse_R10: assert property (@(posedge clk) disable iff (!rst_n)
      done_valid |=> !done_valid);

   assert_hold_read_R11: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_req_valid && !mem_req_ready)
      |=> (mem_req_valid && $stable(mem_req_addr) && $stable(mem_req_size8)));

   assert_one_pending_R11: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_req_valid && mem_req_ready) |=> !mem_req_valid);

endmodule

// File: tb/ptw_top_tb_top.sv
module ptw_top_tb_top;
   localparam int unsigned VA_W = 48;
   localparam int unsigned PA_W = 52;

   logic            clk = 1'b0;
   logic            rst_n = 1'b0;
   logic            req_valid = 1'b0;
   logic            req_ready;
   logic [VA_W-1:0] req_va = '0;
   logic [PA_W-1:0] req_root = '0;
   logic [1:0]      req_mode = 2'd0;
   logic            mem_req_valid;
   logic            mem_req_ready;
   logic [PA_W-1:0] mem_req_addr;
   logic            mem_req_size8;
   logic            mem_rsp_valid = 1'b0;
   logic [63:0]     mem_rsp_data = '0;
   logic            done_valid;
   logic [PA_W-1:0] done_pa;
   logic [1:0]      done_fault_kind;
   logic [1:0]      done_level;

   always #4 clk = ~clk;

   ptw_top #(.VA_W(VA_W), .PA_W(PA_W), .IMPL_PA_W(46)) dut_i (
      .clk(clk), .rst_n(rst_n),
      .req_valid(req_valid), .req_ready(req_ready), .req_va(req_va),
      .req_root(req_root), .req_mode(req_mode),
      .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready),
      .mem_req_addr(mem_req_addr), .mem_req_size8(mem_req_size8),
      .mem_rsp_valid(mem_rsp_valid), .mem_rsp_data(mem_rsp_data),
      .done_valid(done_valid), .done_pa(done_pa),
      .done_fault_kind(done_fault_kind), .done_level(done_level)
   );

   int total = 0;
   int bad = 0;

   logic [63:0] tbl [logic [PA_W-1:0]];
   logic        stall_en = 1'b0;
   logic [1:0]  cyc = '0;
   int          rd_count = 0;
   int          size_bad = 0;
   logic        exp_size8 = 1'b1;
   logic        hold_pend = 1'b0;
   logic [PA_W-1:0] held_addr = '0;
   int          hold_bad = 0;

   assign mem_req_ready = !stall_en || (cyc == 2'b11);

   always @(posedge clk) begin
      cyc <= cyc + 2'd1;
      if (mem_req_valid && mem_req_ready) begin
         mem_rsp_valid <= 1'b1;
         mem_rsp_data  <= tbl.exists(mem_req_addr) ? tbl[mem_req_addr] : 64'h0;
         rd_count      <= rd_count + 1;
         if (mem_req_size8 != exp_size8) size_bad <= size_bad + 1;
      end else begin
         mem_rsp_valid <= 1'b0;
      end
   end

   always @(negedge clk) begin
      if (hold_pend && (!mem_req_valid || mem_req_addr != held_addr)) hold_bad <= hold_bad + 1;
      hold_pend <= mem_req_valid && !mem_req_ready;
      held_addr <= mem_req_addr;
   end

   task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   task automatic walk(input logic [VA_W-1:0] va, input logic [PA_W-1:0] root,
                       input logic [1:0] mode, output logic [PA_W-1:0] pa,
                       output logic [1:0] kind, output logic [1:0] lvl, output int reads);
      int r0;
      bit found;
      @(negedge clk);
      req_va = va; req_root = root; req_mode = mode; req_valid = 1'b1;
      r0 = rd_count;
      @(negedge clk);
      req_valid = 1'b0;
      found = 1'b0;
      for (int i = 0; i < 2000; i++) begin
         if (done_valid) begin found = 1'b1; break; end
         @(negedge clk);
      end
      chk("R10 walk completes", 64'(found), 64'd1);
      pa = done_pa; kind = done_fault_kind; lvl = done_level;
      reads = rd_count - r0;
      @(negedge clk);
      chk("R10 done lasts one cycle", 64'(done_valid), 64'd0);
   endtask

   function automatic logic [VA_W-1:0] va4(input int i3, input int i2, input int i1,
                                           input int i0, input int off);
      return (VA_W'(i3) << 39) | (VA_W'(i2) << 30) | (VA_W'(i1) << 21) |
             (VA_W'(i0) << 12) | VA_W'(off);
   endfunction

   logic [PA_W-1:0] pa;
   logic [1:0]      kind;
   logic [1:0]      lvl;
   int              reads;

   task automatic t_reset();
      chk("R1 req_ready after reset", 64'(req_ready), 64'd1);
      chk("R1 done_valid after reset", 64'(done_valid), 64'd0);
      chk("R1 mem_req_valid after reset", 64'(mem_req_valid), 64'd0);
   endtask

   task automatic build4(input logic [63:0] e3, input logic [63:0] e2,
                         input logic [63:0] e1, input logic [63:0] e0);
      tbl.delete();
      tbl[52'h1000 + 5*8] = e3;
      tbl[52'h2000 + 6*8] = e2;
      tbl[52'h3000 + 7*8] = e1;
      tbl[52'h4000 + 8*8] = e0;
   endtask

   task automatic t_four_level();
      exp_size8 = 1'b1;
      build4(64'h2001, 64'h3001, 64'h4001, 64'h8000_0001_2345_6001);
      walk(va4(5, 6, 7, 8, 'hABC), 52'h1000, 2'd0, pa, kind, lvl, reads);
      chk("R2 4K pa", 64'(pa), 64'h1_2345_6ABC);
      chk("R2 4K fault", 64'(kind), 64'd0);
      chk("R2 4K level", 64'(lvl), 64'd0);
      chk("R2 4K reads", 64'(reads), 64'd4);
   endtask

   task automatic t_large();
      build4(64'h2001, 64'h3001, 64'h8020_5081, 64'h0);
      walk(va4(5, 6, 7, 8, 'hABC), 52'h1000, 2'd0, pa, kind, lvl, reads);
      chk("R3 2M pa", 64'(pa), 64'h8020_8ABC);
      chk("R3 2M level", 64'(lvl), 64'd1);
      chk("R3 2M reads", 64'(reads), 64'd3);
      build4(64'h2001, 64'h1_4000_0081, 64'h0, 64'h0);
      walk(va4(5, 6, 7, 8, 'hABC), 52'h1000, 2'd0, pa, kind, lvl, reads);
      chk("R3 1G pa", 64'(pa), 64'h1_40E0_8ABC);
      chk("R3 1G level", 64'(lvl), 64'd2);
      chk("R3 1G reads", 64'(reads), 64'd2);
   endtask

   task automatic t_ignored_big();
      build4(64'h2081, 64'h3001, 64'h4001, 64'h5081);
      walk(va4(5, 6, 7, 8, 'hABC), 52'h1000, 2'd0, pa, kind, lvl, reads);
      chk("R4 bit7 ignored pa", 64'(pa), 64'h5ABC);
      chk("R4 bit7 ignored reads", 64'(reads), 64'd4);
   endtask

   task automatic t_three_level();
      logic [VA_W-1:0] va;
      exp_size8 = 1'b1;
      va = (VA_W'(1) << 40) | (VA_W'(2) << 30) | (VA_W'(8'h11) << 21) |
           (VA_W'(8'h22) << 12) | VA_W'(12'h345);
      tbl.delete();
      tbl[52'h8000 + 2*8]     = 64'h9001;
      tbl[52'h9000 + 'h11*8]  = 64'hA001;
      tbl[52'hA000 + 'h22*8]  = 64'hDEAD_B001;
      walk(va, 52'h8000, 2'd1, pa, kind, lvl, reads);
      chk("R5 3-level pa", 64'(pa), 64'hDEAD_B345);
      chk("R5 3-level reads", 64'(reads), 64'd3);
      tbl[52'h9000 + 'h11*8]  = 64'h7FE0_0081;
      walk(va, 52'h8000, 2'd1, pa, kind, lvl, reads);
      chk("R5 3-level 2M pa", 64'(pa), 64'h7FE2_2345);
      chk("R5 3-level 2M level", 64'(lvl), 64'd1);
      chk("R5 3-level 2M reads", 64'(reads), 64'd2);
   endtask

   task automatic t_two_level();
      logic [VA_W-1:0] va;
      exp_size8 = 1'b0;
      va = (VA_W'(10'h3FF) << 22) | (VA_W'(1) << 12) | VA_W'(12'h777);
      tbl.delete();
      tbl[52'hC000 + 'h3FF*4] = 64'hFFFF_FFFF_0000_D081;
      tbl[52'hD000 + 1*4]     = 64'h1234_5678_FEDC_B001;
      walk(va, 52'hC000, 2'd2, pa, kind, lvl, reads);
      chk("R6 2-level pa", 64'(pa), 64'hFEDC_B777);
      chk("R6 2-level reads", 64'(reads), 64'd2);
      chk("R6 4-byte size", 64'(size_bad), 64'd0);
      tbl.delete();
      tbl[52'hC000 + 'h3FF*4] = 64'h0000_D001;
      walk(va, 52'hC000, 2'd2, pa, kind, lvl, reads);
      chk("R7 2-level absent kind", 64'(kind), 64'd1);
      chk("R7 2-level absent level", 64'(lvl), 64'd0);
      exp_size8 = 1'b1;
   endtask

   task automatic t_absent();
      build4(64'h2001, 64'h3000, 64'h4001, 64'h5001);
      walk(va4(5, 6, 7, 8, 'hABC), 52'h1000, 2'd0, pa, kind, lvl, reads);
      chk("R7 absent kind", 64'(kind), 64'd1);
      chk("R7 absent level", 64'(lvl), 64'd2);
      chk("R7 absent pa", 64'(pa), 64'd0);
      chk("R7 absent reads", 64'(reads), 64'd2);
   endtask

   task automatic t_reserved();
      build4(64'h2001, 64'h3001, (64'h1 << 46) | 64'h4001, 64'h5001);
      walk(va4(5, 6, 7, 8, 'hABC), 52'h1000, 2'd0, pa, kind, lvl, reads);
      chk("R8 reserved kind", 64'(kind), 64'd2);
      chk("R8 reserved level", 64'(lvl), 64'd1);
      chk("R8 reserved reads", 64'(reads), 64'd3);
      build4(64'h2001, (64'h1 << 50) | 64'h3000, 64'h0, 64'h0);
      walk(va4(5, 6, 7, 8, 'hABC), 52'h1000, 2'd0, pa, kind, lvl, reads);
      chk("R8 present before reserved", 64'(kind), 64'd1);
      build4(64'h2001, 64'h3001, 64'h4001, (64'h1 << 45) | 64'h6001);
      walk(va4(5, 6, 7, 8, 'hABC), 52'h1000, 2'd0, pa, kind, lvl, reads);
      chk("R8 bit45 valid pa", 64'(pa), (64'h1 << 45) | 64'h6ABC);
      chk("R8 bit45 valid kind", 64'(kind), 64'd0);
   endtask

   task automatic t_bad_mode();
      walk(va4(1, 1, 1, 1, 0), 52'h1000, 2'd3, pa, kind, lvl, reads);
      chk("R9 bad format kind", 64'(kind), 64'd3);
      chk("R9 bad format level", 64'(lvl), 64'd0);
      chk("R9 bad format reads", 64'(reads), 64'd0);
   endtask

   task automatic t_busy();
      bit seen_ready;
      int dones;
      int r0;
      build4(64'h2001, 64'h3001, 64'h4001, 64'h7001);
      @(negedge clk);
      req_va = va4(5, 6, 7, 8, 'h123); req_root = 52'h1000; req_mode = 2'd0; req_valid = 1'b1;
      r0 = rd_count;
      @(negedge clk);
      req_va = va4(1, 2, 3, 4, 'h0); req_mode = 2'd3;
      seen_ready = 1'b0;
      for (int i = 0; i < 200; i++) begin
         if (done_valid) break;
         if (req_ready) seen_ready = 1'b1;
         @(negedge clk);
      end
      req_valid = 1'b0;
      chk("R10 ready low while busy", 64'(seen_ready), 64'd0);
      chk("R10 busy request ignored pa", 64'(done_pa), 64'h7123);
      dones = 0;
      for (int i = 0; i < 20; i++) begin
         @(negedge clk);
         if (done_valid) dones++;
      end
      chk("R10 no second result", 64'(dones), 64'd0);
      chk("R10 reads for one walk", 64'(rd_count - r0), 64'd4);
   endtask

   task automatic t_stall();
      stall_en = 1'b1;
      build4(64'h2001, 64'h3001, 64'h4001, 64'h9001);
      walk(va4(5, 6, 7, 8, 'h456), 52'h1000, 2'd0, pa, kind, lvl, reads);
      stall_en = 1'b0;
      chk("R11 stalled walk pa", 64'(pa), 64'h9456);
      chk("R11 stalled walk reads", 64'(reads), 64'd4);
      chk("R11 address held while stalled", 64'(hold_bad), 64'd0);
      chk("R2 8-byte size", 64'(size_bad), 64'd0);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_four_level();
      t_large();
      t_ignored_big();
      t_three_level();
      t_two_level();
      t_absent();
      t_reserved();
      t_bad_mode();
      t_busy();
      t_stall();
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      #(8 * 150000);
      total++;
      bad++;
      $display("FAIL watchdog: run did not finish actual=hung expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

endmodule